// File: doc/BRIEF.md
# Two-Wire Serial-Memory Target

This block lets a small on-chip byte array answer on a two-wire serial bus in the way a serial EEPROM does. A fast system clock samples the bus clock and data lines. The block finds start and stop conditions and compares the first byte of each transfer with its own 7-bit device address. It then takes a word address and data bytes for a write, or streams data bytes back for a read. Both bus lines are open drain, so the block never drives a line high. Its only output is an enable that pulls the data line low.

The upper four bits of the device address come from a parameter and the lower three from select pins, so up to eight instances can share one bus. A write-protect input makes the block refuse write data. Another parameter decides whether protection covers the whole array or only the half with the highest addresses. Memory depth is a parameter and may be 128, 256, 512 or 1024 bytes. The system clock must run at least 16 times faster than the bus clock.

Top module: `i2c_mem_target`

## Requirements
- R1: The only bus output is `sda_pull_o`, where 1 means pull SDA low. It is 0 during reset and whenever the block is idle.
- R2: A falling SDA while SCL is high is a start condition. It begins a new address phase from any state, and the word pointer is kept. A rising SDA while SCL is high is a stop condition. It returns the block to idle from any state, releases SDA and discards any partly received byte.
- R3: Received bits are sampled on the rising edge of SCL. `sda_pull_o` is asserted only while SCL is low.
- R4: The device address is {`DEV_HI`, `addr_sel_i`}, with `addr_sel_i[2]` as the lower address bit 2. The first byte after a start holds the address in bits 7..1 and R/W in bit 0, where 1 means read. A matching address is acknowledged by pulling SDA low during the ninth SCL pulse. A non-matching address gets no acknowledge, and later bytes are ignored until the next start.
- R5: For a write, R/W is 0. The next byte loads the word pointer and each byte after it is stored at the pointer. Every one of these bytes is acknowledged.
- R6: While `wp_i` is 1, write data bytes are still acknowledged but the memory is left unchanged. With `WP_UPPER_ONLY`=1 only addresses whose top pointer bit is 1 are protected. With `WP_UPPER_ONLY`=0 every address is protected.
- R7: The pointer increases by one after each data byte written or read, and it wraps from `MEM_DEPTH`-1 to 0.
- R8: For a read, R/W is 1. The block sends the byte at the pointer MSB first and keeps sending while the master acknowledges. After a master NACK it releases SDA and stays idle until the next start.
- R9: A repeated start after a word-address byte, followed by a read address, returns data starting at that word address.
- R10: A word-address byte sets the pointer to the byte value reduced modulo `MEM_DEPTH`. When the depth is 128, bit 7 is ignored. When the depth is above 256, the upper pointer bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 3 | Lower three device-address bits |
| wp_i | input | 1 | Write protect, active high |

## Verification
A data-byte commit and the pointer wrap take place in the same system clock cycle. The bench forces this with upper-half protection active. It writes a run that starts two bytes below the top of the array, so the last protected write lands together with the wrap to address 0. A readback then shows that the top two bytes are unchanged while addresses 0 and 1 hold the new data. A stop placed in the middle of a byte is judged the same way. The byte that was cut off must not reach the array, and the next transfer must be answered normally.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK
  } bus_state_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_CNT_W = 3;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int unsigned PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] scl_pipe_q, scl_pipe_d;
  logic [PIPE_W-1:0] sda_pipe_q, sda_pipe_d;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[PIPE_W-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[PIPE_W-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;

  always_comb begin
    scl_now    = scl_pipe_q[SYNC_STAGES-1];
    scl_old    = scl_pipe_q[SYNC_STAGES];
    sda_now    = sda_pipe_q[SYNC_STAGES-1];
    sda_old    = sda_pipe_q[SYNC_STAGES];
    scl_lvl_o  = scl_now;
    sda_lvl_o  = sda_now;
    scl_rise_o = scl_now & ~scl_old;
    scl_fall_o = ~scl_now & scl_old;
    start_o    = scl_now & scl_old & sda_old & ~sda_now;
    stop_o     = scl_now & scl_old & ~sda_old & sda_now;
  end

endmodule

// File: rtl/i2c_mem_engine.sv
module i2c_mem_engine
  import i2c_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter logic [3:0]  DEV_HI = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        addr_sel_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_pull_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o
);

  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);
  localparam logic [ADDR_W-1:0]    PTR_ONE  = ADDR_W'(1);

  bus_state_t             state_q, state_d;
  logic [BIT_CNT_W-1:0]   bit_q, bit_d;
  logic [BYTE_W-1:0]      sh_q, sh_d;
  logic [ADDR_W-1:0]      ptr_q, ptr_d;
  logic                   pull_q, pull_d;
  logic                   ackon_q, ackon_d;
  logic                   rw_q, rw_d;
  logic                   more_q, more_d;
  logic [BYTE_W-1:0]      rx_byte;
  logic [ADDR_W+BYTE_W-1:0] wadr_ext;
  logic [6:0]             dev_id;

  always_comb begin
    dev_id   = {DEV_HI, addr_sel_i};
    rx_byte  = {sh_q[BYTE_W-2:0], sda_i};
    wadr_ext = {{ADDR_W{1'b0}}, rx_byte};
  end

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    ptr_d    = ptr_q;
    pull_d   = pull_q;
    ackon_d  = ackon_q;
    rw_d     = rw_q;
    more_d   = more_q;
    wr_en_o  = 1'b0;
    if (stop_i) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
      ackon_d = 1'b0;
    end else if (start_i) begin
      state_d = ST_DEV;
      bit_d   = '0;
      pull_d  = 1'b0;
      ackon_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          pull_d = 1'b0;
        end
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise_i) begin
            sh_d  = rx_byte;
            bit_d = bit_q + 1'b1;
            if (bit_q == LAST_BIT) begin
              if (state_q == ST_DEV) begin
                if (rx_byte[BYTE_W-1:1] == dev_id) begin
                  rw_d    = rx_byte[0];
                  state_d = ST_DEV_ACK;
                end else begin
                  state_d = ST_IDLE;
                end
              end else if (state_q == ST_WADR) begin
                ptr_d   = wadr_ext[ADDR_W-1:0];
                state_d = ST_WADR_ACK;
              end else begin
                wr_en_o = 1'b1;
                ptr_d   = ptr_q + PTR_ONE;
                state_d = ST_WDAT_ACK;
              end
            end
          end
        end
        ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK: begin
          if (scl_fall_i) begin
            if (!ackon_q) begin
              pull_d  = 1'b1;
              ackon_d = 1'b1;
            end else begin
              ackon_d = 1'b0;
              bit_d   = '0;
              if (state_q == ST_DEV_ACK && rw_q) begin
                state_d = ST_RDAT;
                sh_d    = rd_data_i;
                pull_d  = ~rd_data_i[BYTE_W-1];
              end else begin
                state_d = (state_q == ST_DEV_ACK) ? ST_WADR : ST_WDAT;
                pull_d  = 1'b0;
              end
            end
          end
        end
        ST_RDAT: begin
          if (scl_fall_i) begin
            if (bit_q == LAST_BIT) begin
              pull_d  = 1'b0;
              ptr_d   = ptr_q + PTR_ONE;
              state_d = ST_RACK;
            end else begin
              sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
              pull_d = ~sh_q[BYTE_W-2];
              bit_d  = bit_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            more_d = ~sda_i;
          end
          if (scl_fall_i) begin
            if (more_q) begin
              state_d = ST_RDAT;
              sh_d    = rd_data_i;
              pull_d  = ~rd_data_i[BYTE_W-1];
              bit_d   = '0;
            end else begin
              state_d = ST_IDLE;
              pull_d  = 1'b0;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
          pull_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      pull_q  <= 1'b0;
      ackon_q <= 1'b0;
      rw_q    <= 1'b0;
      more_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      pull_q  <= pull_d;
      ackon_q <= ackon_d;
      rw_q    <= rw_d;
      more_q  <= more_d;
    end
  end

  always_comb begin
    sda_pull_o = pull_q;
    ptr_o      = ptr_q;
    wr_data_o  = rx_byte;
  end

  // R1: idle means the line is released
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_pull_o);

  // R2: a start condition always opens an address phase
  assert_start_opens_dev_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> (state_q == ST_DEV));

  // R2: a stop condition always ends in idle with the line free
  assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (state_q == ST_IDLE && !sda_pull_o));

  // R7: each committed data byte advances the pointer by one
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (ptr_o == $past(ptr_o) + PTR_ONE));

endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store
  import i2c_mem_pkg::*;
#(
  parameter int unsigned MEM_DEPTH     = 128,
  parameter int unsigned ADDR_W        = 7,
  parameter bit          WP_UPPER_ONLY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              wp_i,
  output logic [BYTE_W-1:0] rd_data_o
);

  logic [BYTE_W-1:0] mem_q [MEM_DEPTH];
  logic              blocked;
  logic              commit;

  generate
    if (WP_UPPER_ONLY) begin : g_wp_upper
      always_comb blocked = wp_i & addr_i[ADDR_W-1];
    end else begin : g_wp_all
      always_comb blocked = wp_i;
    end
  endgenerate

  always_comb commit = wr_en_i & ~blocked;

  always_ff @(posedge clk) begin
    if (commit) begin
      mem_q[addr_i] <= wr_data_i;
    end
  end

  always_comb rd_data_o = mem_q[addr_i];

  // R6: a write refused by protection leaves the addressed byte as it was
  assert_wp_holds_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wp_i && (!WP_UPPER_ONLY || addr_i[ADDR_W-1]))
      |=> (mem_q[$past(addr_i)] == $past(rd_data_o)));

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int unsigned MEM_DEPTH     = 128,
  parameter logic [3:0]  DEV_HI        = 4'b1010,
  parameter bit          WP_UPPER_ONLY = 1'b1,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] addr_sel_i,
  input  logic       wp_i
);

  localparam int unsigned ADDR_W = $clog2(MEM_DEPTH);

  logic [1:0] rst_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  always_comb rst_n = rst_q[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;
  logic [ADDR_W-1:0] ptr;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic              pull;

  i2c_line_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl_o (scl_lvl),
    .sda_lvl_o (sda_lvl),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_c),
    .stop_o    (stop_c)
  );

  i2c_mem_engine #(
    .ADDR_W(ADDR_W),
    .DEV_HI(DEV_HI)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_i     (sda_lvl),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_c),
    .stop_i    (stop_c),
    .addr_sel_i(addr_sel_i),
    .rd_data_i (rd_data),
    .sda_pull_o(pull),
    .ptr_o     (ptr),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data)
  );

  i2c_mem_store #(
    .MEM_DEPTH    (MEM_DEPTH),
    .ADDR_W       (ADDR_W),
    .WP_UPPER_ONLY(WP_UPPER_ONLY)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en),
    .addr_i   (ptr),
    .wr_data_i(wr_data),
    .wp_i     (wp_i),
    .rd_data_o(rd_data)
  );

  always_comb sda_pull_o = pull;

  // R3: the pull-low is only ever switched on while the bus clock is low
  assert_pull_on_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_lvl);

endmodule

// File: tb/i2c_mem_target_bench.sv
module i2c_mem_target_bench;

  localparam int Q = 8;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp_a = 1'b0;
  logic wp_b = 1'b0;
  logic pull_a, pull_b;
  logic sda_line;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_a [DEPTH];
  logic [7:0] exp_b [DEPTH];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~pull_a & ~pull_b;

  i2c_mem_target #(.MEM_DEPTH(DEPTH), .WP_UPPER_ONLY(1'b1)) u_i2c_mem_target (
    .clk(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(pull_a), .addr_sel_i(3'b001), .wp_i(wp_a));

  i2c_mem_target #(.MEM_DEPTH(DEPTH), .WP_UPPER_ONLY(1'b0)) u_i2c_mem_target_wpall (
    .clk(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(pull_b), .addr_sel_i(3'b110), .wp_i(wp_b));

  localparam logic [7:0] DEV_A = 8'hA2;  // 1010_001
  localparam logic [7:0] DEV_B = 8'hAC;  // 1010_110

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 37 + salt * 101 + 11) & 8'hFF);
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; wt(Q);
    scl_m = 1'b1; wt(Q);
    s = sda_line; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~m_ack, s);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    wt(10);
    check(pull_a, 0, "R1 reset A");
    check(pull_b, 0, "R1 reset B");
    rst_ni = 1'b1;
    wt(10);

    // R5: full sweep write of device A from word 0
    bus_start();
    send_byte(DEV_A, ack); check(ack, 1, "R4 match A");
    send_byte(8'h00, ack); check(ack, 1, "R5 word ack");
    for (int a = 0; a < DEPTH; a++) begin
      send_byte(pat(a, 0), ack); check(ack, 1, "R5 data ack");
      exp_a[a] = pat(a, 0);
    end
    bus_stop();
    check(pull_a, 0, "R1 idle after stop");

    // R9 random read, R8 sequential, R7 wrap past the top
    bus_start();
    send_byte(DEV_A, ack); check(ack, 1, "R4 match A");
    send_byte(8'h00, ack); check(ack, 1, "R9 word ack");
    bus_start();
    send_byte(DEV_A | 8'h01, ack); check(ack, 1, "R9 read addr ack");
    for (int i = 0; i < DEPTH + 2; i++) begin
      recv_byte(i != DEPTH + 1, b);
      check(b, exp_a[i % DEPTH], (i >= DEPTH) ? "R7 wrap read" : "R8 read");
    end
    bus_stop();
    check(pull_a, 0, "R8 released after NACK");

    // R8 current-address read continues at pointer 2
    bus_start();
    send_byte(DEV_A | 8'h01, ack); check(ack, 1, "R8 addr ack");
    recv_byte(1'b0, b); check(b, exp_a[2], "R8 current address");
    bus_stop();

    // R4 foreign addresses are not acknowledged, following bytes ignored
    bus_start();
    send_byte(8'hA6, ack); check(ack, 0, "R4 wrong pins");
    send_byte(8'h00, ack); check(ack, 0, "R4 ignored byte");
    bus_stop();
    bus_start();
    send_byte(8'h42, ack); check(ack, 0, "R4 wrong upper bits");
    bus_stop();

    // R6 upper-half protection while the write wraps to 0
    wp_a = 1'b1;
    bus_start();
    send_byte(DEV_A, ack); check(ack, 1, "R4 match A");
    send_byte(8'd126, ack); check(ack, 1, "R6 word ack");
    for (int i = 0; i < 4; i++) begin
      send_byte(pat(i, 3), ack); check(ack, 1, "R6 protected data ack");
      if (((126 + i) % DEPTH) < DEPTH / 2) exp_a[(126 + i) % DEPTH] = pat(i, 3);
    end
    bus_stop();
    wp_a = 1'b0;
    bus_start();
    send_byte(DEV_A, ack);
    send_byte(8'd126, ack);
    bus_start();
    send_byte(DEV_A | 8'h01, ack);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, b);
      check(b, exp_a[(126 + i) % DEPTH], "R6 upper-only readback");
    end
    bus_stop();

    // R10 bit 7 of the word address ignored at depth 128
    bus_start();
    send_byte(DEV_A, ack);
    send_byte(8'h85, ack); check(ack, 1, "R10 word ack");
    send_byte(8'h5A, ack); exp_a[5] = 8'h5A;
    bus_stop();
    bus_start();
    send_byte(DEV_A, ack);
    send_byte(8'h05, ack);
    bus_start();
    send_byte(DEV_A | 8'h01, ack);
    recv_byte(1'b0, b); check(b, 8'h5A, "R10 folded word address");
    bus_stop();

    // R2 stop in the middle of a data byte discards it
    bus_start();
    send_byte(DEV_A, ack);
    send_byte(8'h10, ack);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, ack);
    bus_stop();
    check(pull_a, 0, "R2 idle after early stop");
    bus_start();
    send_byte(DEV_A, ack); check(ack, 1, "R2 answers after early stop");
    send_byte(8'h10, ack);
    bus_start();
    send_byte(DEV_A | 8'h01, ack);
    recv_byte(1'b0, b); check(b, exp_a[16], "R2 partial byte not stored");
    bus_stop();

    // R6 full protection on device B
    bus_start();
    send_byte(DEV_B, ack); check(ack, 1, "R4 match B");
    send_byte(8'h70, ack);
    for (int i = 0; i < 16; i++) begin
      send_byte(pat(i, 5), ack);
      exp_b[8'h70 + i] = pat(i, 5);
    end
    bus_stop();
    wp_b = 1'b1;
    bus_start();
    send_byte(DEV_B, ack);
    send_byte(8'h70, ack);
    for (int i = 0; i < 16; i++) begin
      send_byte(pat(i, 7), ack); check(ack, 1, "R6 full-protect ack");
    end
    bus_stop();
    wp_b = 1'b0;
    bus_start();
    send_byte(DEV_B, ack);
    send_byte(8'h70, ack);
    bus_start();
    send_byte(DEV_B | 8'h01, ack);
    for (int i = 0; i < 16; i++) begin
      recv_byte(i != 15, b);
      check(b, exp_b[8'h70 + i], "R6 full-protect readback");
    end
    bus_stop();
    check(pull_b, 0, "R1 B idle");
    check(pull_a, 0, "R1 A idle");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule